// File: doc/BRIEF.md
# Microprogram Sequencer Slice with Repeat Counter

This block is a 4-bit slice of a microprogram address sequencer. On each clock it picks the next control-store address. The choice comes from a 5-bit operation code that a small decode network turns into source selects and register actions, so the caller never drives raw multiplexer selects. The slice holds the current address and a repeat/counter register. That register saves a return point on a branch and can count loop passes. It also holds an instruction register for a captured branch target, a 4-bit status register whose bits can be written one at a time, and a four-word last-in-first-out stack for subroutine returns.

Sequential stepping adds the carry-in to the current address. A carry-out is produced so that several slices can be chained into a wider address. The stack is built as a shift structure: its deepest word is zero unless four entries are live, so a nonzero deepest word raises the stack-full flag. Separate input and output ports take the place of shared bidirectional buses. The output bus presents the repeat/counter register.

Top module: `useq_slice`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the address, repeat, instruction and status registers and every stack word, so addr_out, obus_out and stk_full read 0 afterwards.
- R2: Operation 0 (continue) loads addr_out+cin into the address, wrapping modulo 16. cout is high in the same cycle exactly when cin is 1 and addr_out is 15.
- R3: Operation 1 loads na_in, operation 15 loads ibus_in, operation 14 loads the status register, and operation 16 holds the current address.
- R4: Operation 9 captures ibus_in into the instruction register and steps the address by cin. Operation 2 later jumps to the captured value.
- R5: Operation 3 (branch and save) copies the current address into the repeat register and jumps to na_in. Operation 4 (repeat) loads the repeat register back into the address.
- R6: Operation 5 (loop) decrements the repeat register and jumps to na_in while the register is nonzero. When it is zero, the register stays 0 and the address steps by cin.
- R7: Operation 13 adds cin to the repeat register and steps the address by cin.
- R8: Operation 6 (call) pushes addr_out+cin and jumps to na_in. Operation 7 (return) loads the top word into the address and pops. The stack returns words last-in-first-out, and a return on an empty stack yields address 0.
- R9: stk_full is high exactly when the deepest of the four stack words is nonzero. A fifth push discards the oldest entry. A pop zero-fills the deepest word, so stk_full is low after any return.
- R10: Operation 10 loads the status register from na_in, and operation 11 loads it from ibus_in. Both step the address by cin.
- R11: Operation 12 writes din_in into the status bit numbered sel_in (bit 0 is the LSB), leaves the other bits unchanged, and steps the address by cin.
- R12: Operation 8 jumps to na_in when status bit sel_in is 1, and otherwise steps the address by cin.
- R13: Operation codes 17 to 31 behave as continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_in | input | 5 | Operation code |
| na_in | input | 4 | Next-address field |
| ibus_in | input | 4 | Input bus |
| din_in | input | 1 | Value for a single status bit write |
| sel_in | input | 2 | Status bit number for bit write and bit branch |
| cin | input | 1 | Carry-in of the incrementer |
| addr_out | output | 4 | Current address register |
| obus_out | output | 4 | Output bus, showing the repeat/counter register |
| cout | output | 1 | Carry-out of the address incrementer |
| stk_full | output | 1 | Deepest stack word is nonzero |

## Verification
Every registered result (addr_out, obus_out, stk_full) changes at the first rising edge after the operation is applied, so it is due one cycle later. cout is combinational and is due in the same cycle as its inputs. The bench drives inputs on the falling edge, lets one rising edge pass and samples on the next falling edge. It checks cout a nanosecond after the inputs settle and before any edge. Registers with no port of their own (instruction register, status register, stack) are read back through the operations that route them into the address: jump to instruction register, jump to status, and return.

// File: rtl/useq_pkg.sv
package useq_pkg;

    typedef enum logic [4:0] {
        OP_CONT     = 5'd0,
        OP_JMP_NA   = 5'd1,
        OP_JMP_IR   = 5'd2,
        OP_BR_SAVE  = 5'd3,
        OP_REPEAT   = 5'd4,
        OP_LOOP     = 5'd5,
        OP_CALL     = 5'd6,
        OP_RET      = 5'd7,
        OP_BR_STAT  = 5'd8,
        OP_LD_IR    = 5'd9,
        OP_LD_ST_NA = 5'd10,
        OP_LD_ST_IB = 5'd11,
        OP_WR_BIT   = 5'd12,
        OP_INC_RPT  = 5'd13,
        OP_JMP_ST   = 5'd14,
        OP_JMP_IB   = 5'd15,
        OP_HOLD     = 5'd16
    } useq_op_e;

    typedef enum logic [2:0] {
        SRC_INC,
        SRC_NA,
        SRC_IR,
        SRC_RPT,
        SRC_STK,
        SRC_ST,
        SRC_IB,
        SRC_HOLD
    } addr_src_e;

    typedef enum logic [1:0] {
        RPT_KEEP,
        RPT_SAVE,
        RPT_DEC,
        RPT_INC
    } rpt_act_e;

    typedef enum logic [1:0] {
        ST_KEEP,
        ST_LD_NA,
        ST_LD_IB,
        ST_WRBIT
    } st_act_e;

    typedef struct packed {
        addr_src_e src;
        rpt_act_e  rpt;
        st_act_e   st;
        logic      ir_ld;
        logic      push;
        logic      pop;
    } useq_ctl_t;

endpackage

// File: rtl/useq_incr.sv
module useq_incr #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    // Carry chain of one slice; cout feeds the next slice's cin.
    always_comb begin
        {cout, sum} = {1'b0, a} + {{W{1'b0}}, cin};
    end
endmodule

// File: rtl/useq_stack.sv
module useq_stack #(
    parameter int W     = 4,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         full
);
    logic [W-1:0] word_q [DEPTH];

    // Shift structure: word 0 is the top, word DEPTH-1 the deepest.
    for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
        logic [W-1:0] from_above;
        logic [W-1:0] from_below;

        if (i == 0) begin : g_top
            assign from_above = din;
        end else begin : g_mid
            assign from_above = word_q[i-1];
        end

        if (i == DEPTH - 1) begin : g_deep
            assign from_below = '0;
        end else begin : g_up
            assign from_below = word_q[i+1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[i] <= '0;
            end else if (push) begin
                word_q[i] <= from_above;
            end else if (pop) begin
                word_q[i] <= from_below;
            end
        end
    end

    assign top  = word_q[0];
    assign full = |word_q[DEPTH-1];
endmodule

// File: rtl/useq_nextaddr.sv
module useq_nextaddr
    import useq_pkg::*;
(
    input  logic [4:0] op,
    input  logic       stat_bit,
    input  logic       rpt_nz,
    output useq_ctl_t  ctl
);
    always_comb begin
        ctl       = '0;
        ctl.src   = SRC_INC;
        ctl.rpt   = RPT_KEEP;
        ctl.st    = ST_KEEP;
        unique case (op)
            OP_JMP_NA:   ctl.src = SRC_NA;
            OP_JMP_IR:   ctl.src = SRC_IR;
            OP_BR_SAVE: begin
                ctl.src = SRC_NA;
                ctl.rpt = RPT_SAVE;
            end
            OP_REPEAT:   ctl.src = SRC_RPT;
            OP_LOOP: begin
                if (rpt_nz) begin
                    ctl.src = SRC_NA;
                    ctl.rpt = RPT_DEC;
                end
            end
            OP_CALL: begin
                ctl.src  = SRC_NA;
                ctl.push = 1'b1;
            end
            OP_RET: begin
                ctl.src = SRC_STK;
                ctl.pop = 1'b1;
            end
            OP_BR_STAT:  ctl.src = stat_bit ? SRC_NA : SRC_INC;
            OP_LD_IR:    ctl.ir_ld = 1'b1;
            OP_LD_ST_NA: ctl.st = ST_LD_NA;
            OP_LD_ST_IB: ctl.st = ST_LD_IB;
            OP_WR_BIT:   ctl.st = ST_WRBIT;
            OP_INC_RPT:  ctl.rpt = RPT_INC;
            OP_JMP_ST:   ctl.src = SRC_ST;
            OP_JMP_IB:   ctl.src = SRC_IB;
            OP_HOLD:     ctl.src = SRC_HOLD;
            default:     ctl.src = SRC_INC;
        endcase
    end
endmodule

// File: rtl/useq_slice.sv
module useq_slice
    import useq_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int STK_DEPTH = 4,
    localparam int SEL_W    = $clog2(ADDR_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        op_in,
    input  logic [ADDR_W-1:0] na_in,
    input  logic [ADDR_W-1:0] ibus_in,
    input  logic              din_in,
    input  logic [SEL_W-1:0]  sel_in,
    input  logic              cin,
    output logic [ADDR_W-1:0] addr_out,
    output logic [ADDR_W-1:0] obus_out,
    output logic              cout,
    output logic              stk_full
);
    logic [ADDR_W-1:0] addr_q, rpt_q, ir_q, st_q;
    logic [ADDR_W-1:0] addr_inc, stk_top, addr_nxt;
    useq_ctl_t         ctl;

    useq_incr #(.W(ADDR_W)) u_ainc (
        .a    (addr_q),
        .cin  (cin),
        .sum  (addr_inc),
        .cout (cout)
    );

    useq_nextaddr u_dec (
        .op       (op_in),
        .stat_bit (st_q[sel_in]),
        .rpt_nz   (|rpt_q),
        .ctl      (ctl)
    );

    useq_stack #(.W(ADDR_W), .DEPTH(STK_DEPTH)) u_stk (
        .clk  (clk),
        .rst  (rst),
        .push (ctl.push),
        .pop  (ctl.pop),
        .din  (addr_inc),
        .top  (stk_top),
        .full (stk_full)
    );

    always_comb begin
        unique case (ctl.src)
            SRC_INC:  addr_nxt = addr_inc;
            SRC_NA:   addr_nxt = na_in;
            SRC_IR:   addr_nxt = ir_q;
            SRC_RPT:  addr_nxt = rpt_q;
            SRC_STK:  addr_nxt = stk_top;
            SRC_ST:   addr_nxt = st_q;
            SRC_IB:   addr_nxt = ibus_in;
            SRC_HOLD: addr_nxt = addr_q;
            default:  addr_nxt = addr_inc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            rpt_q  <= '0;
            ir_q   <= '0;
            st_q   <= '0;
        end else begin
            addr_q <= addr_nxt;
            if (ctl.ir_ld) begin
                ir_q <= ibus_in;
            end
            unique case (ctl.rpt)
                RPT_SAVE: rpt_q <= addr_q;
                RPT_DEC:  rpt_q <= rpt_q - ADDR_W'(1);
                RPT_INC:  rpt_q <= rpt_q + ADDR_W'(cin);
                default:  rpt_q <= rpt_q;
            endcase
            unique case (ctl.st)
                ST_LD_NA: st_q <= na_in;
                ST_LD_IB: st_q <= ibus_in;
                ST_WRBIT: st_q[sel_in] <= din_in;
                default:  st_q <= st_q;
            endcase
        end
    end

    assign addr_out = addr_q;
    assign obus_out = rpt_q;
endmodule

// File: rtl/useq_slice_chk.sv
module useq_slice_chk
    import useq_pkg::*;
#(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst,
    input logic [4:0]   op,
    input logic [W-1:0] na,
    input logic         cin,
    input logic [W-1:0] addr,
    input logic [W-1:0] rpt,
    input logic         full
);
    // R2
    a_r2_cont_step: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CONT) |=> (addr == $past(addr) + W'($past(cin))));

    // R3
    a_r3_jump_na: assert property (@(posedge clk) disable iff (rst)
        (op == OP_JMP_NA) |=> (addr == $past(na)));

    // R5
    a_r5_save_addr: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BR_SAVE) |=> (rpt == $past(addr) && addr == $past(na)));

    // R6
    a_r6_loop_taken: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOOP && rpt != '0) |=> (addr == $past(na) && rpt == $past(rpt) - W'(1)));

    // R6
    a_r6_loop_exit: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOOP && rpt == '0) |=> (rpt == '0 && addr == $past(addr) + W'($past(cin))));

    // R9
    a_r9_pop_clears_full: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RET) |=> !full);
endmodule

bind useq_slice useq_slice_chk #(.W(ADDR_W)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .op   (op_in),
    .na   (na_in),
    .cin  (cin),
    .addr (addr_out),
    .rpt  (rpt_q),
    .full (stk_full)
);

// File: tb/useq_slice_test.sv
`timescale 1ns/1ps
module useq_slice_test;
    logic       clk = 1'b0;
    logic       rst;
    logic [4:0] op_in;
    logic [3:0] na_in, ibus_in;
    logic       din_in;
    logic [1:0] sel_in;
    logic       cin;
    logic [3:0] addr_out, obus_out;
    logic       cout, stk_full;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    useq_slice uut (
        .clk      (clk),
        .rst      (rst),
        .op_in    (op_in),
        .na_in    (na_in),
        .ibus_in  (ibus_in),
        .din_in   (din_in),
        .sel_in   (sel_in),
        .cin      (cin),
        .addr_out (addr_out),
        .obus_out (obus_out),
        .cout     (cout),
        .stk_full (stk_full)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, pass one rising edge, return on the next falling edge.
    task automatic step(input int op, input int na, input int ib, input int c);
        op_in   = 5'(op);
        na_in   = 4'(na);
        ibus_in = 4'(ib);
        cin     = c[0];
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        step(6, 5, 0, 1);
        step(6, 7, 0, 1);
        rst = 1'b0;
        chk("R1 addr", addr_out, 0);
        chk("R1 obus", obus_out, 0);
        chk("R1 full", stk_full, 0);
        step(7, 0, 0, 0);
        chk("R1 stack empty", addr_out, 0);
    endtask

    task automatic t_cont;
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);
        chk("R2 step by one", addr_out, 3);
        step(0, 0, 0, 0);
        chk("R2 cin zero holds", addr_out, 3);
        step(1, 15, 0, 0);
        op_in = 5'd0; cin = 1'b1;
        #1;
        chk("R2 cout at 15", cout, 1);
        cin = 1'b0;
        #1;
        chk("R2 cout without cin", cout, 0);
        step(0, 0, 0, 1);
        chk("R2 wrap", addr_out, 0);
    endtask

    task automatic t_jumps;
        step(1, 9, 0, 1);
        chk("R3 jump na", addr_out, 9);
        step(15, 0, 5, 1);
        chk("R3 jump ibus", addr_out, 5);
        step(16, 2, 3, 1);
        chk("R3 hold", addr_out, 5);
    endtask

    task automatic t_ir;
        step(9, 0, 11, 1);
        chk("R4 load ir steps", addr_out, 6);
        step(2, 0, 0, 1);
        chk("R4 jump ir", addr_out, 11);
    endtask

    task automatic t_save;
        step(3, 2, 0, 1);
        chk("R5 save jump", addr_out, 2);
        chk("R5 saved value", obus_out, 11);
        step(0, 0, 0, 1);
        step(4, 0, 0, 1);
        chk("R5 repeat", addr_out, 11);
    endtask

    task automatic t_loop;
        step(1, 2, 0, 1);
        step(3, 7, 0, 1);
        chk("R6 count set", obus_out, 2);
        step(5, 7, 0, 1);
        chk("R6 loop taken addr", addr_out, 7);
        chk("R6 loop taken count", obus_out, 1);
        step(5, 7, 0, 1);
        chk("R6 second pass", obus_out, 0);
        step(5, 7, 0, 1);
        chk("R6 exit addr", addr_out, 8);
        chk("R6 exit count", obus_out, 0);
    endtask

    task automatic t_incrpt;
        step(13, 0, 0, 1);
        step(13, 0, 0, 1);
        chk("R7 count up", obus_out, 2);
        chk("R7 addr steps", addr_out, 10);
        step(13, 0, 0, 0);
        chk("R7 cin zero", obus_out, 2);
    endtask

    task automatic t_stack;
        step(6, 1, 0, 1);
        step(6, 4, 0, 1);
        step(6, 6, 0, 1);
        chk("R9 three deep not full", stk_full, 0);
        step(6, 12, 0, 1);
        chk("R8 call target", addr_out, 12);
        chk("R9 four deep full", stk_full, 1);
        step(7, 0, 0, 1);
        chk("R8 ret 1", addr_out, 7);
        chk("R9 pop clears full", stk_full, 0);
        step(7, 0, 0, 1);
        chk("R8 ret 2", addr_out, 5);
        step(7, 0, 0, 1);
        chk("R8 ret 3", addr_out, 2);
        step(7, 0, 0, 1);
        chk("R8 ret 4", addr_out, 11);
        step(7, 0, 0, 1);
        chk("R8 ret empty", addr_out, 0);
    endtask

    task automatic t_overflow;
        step(1, 0, 0, 0);
        for (int k = 1; k <= 5; k++) begin
            step(6, k, 0, 1);
        end
        chk("R9 full after five", stk_full, 1);
        step(7, 0, 0, 1);
        chk("R9 newest first", addr_out, 5);
        step(7, 0, 0, 1);
        step(7, 0, 0, 1);
        step(7, 0, 0, 1);
        chk("R9 oldest dropped", addr_out, 2);
        step(7, 0, 0, 1);
        chk("R9 then empty", addr_out, 0);
    endtask

    task automatic t_status;
        step(10, 10, 0, 0);
        step(14, 0, 0, 0);
        chk("R10 status from na", addr_out, 10);
        step(11, 0, 6, 0);
        step(14, 0, 0, 0);
        chk("R10 status from ibus", addr_out, 6);
        din_in = 1'b1; sel_in = 2'd0;
        step(12, 0, 0, 0);
        din_in = 1'b0; sel_in = 2'd2;
        step(12, 0, 0, 0);
        step(14, 0, 0, 0);
        chk("R11 set bit0 clear bit2", addr_out, 3);
        din_in = 1'b1; sel_in = 2'd3;
        step(12, 0, 0, 1);
        chk("R11 write steps addr", addr_out, 4);
        step(14, 0, 0, 0);
        chk("R11 set bit3", addr_out, 11);
    endtask

    task automatic t_brstat;
        step(1, 0, 0, 0);
        sel_in = 2'd2;
        step(8, 9, 0, 1);
        chk("R12 bit clear falls through", addr_out, 1);
        sel_in = 2'd1;
        step(8, 9, 0, 1);
        chk("R12 bit set branches", addr_out, 9);
    endtask

    task automatic t_unused;
        step(20, 3, 3, 1);
        chk("R13 code 20 continues", addr_out, 10);
        step(31, 3, 3, 1);
        chk("R13 code 31 continues", addr_out, 11);
    endtask

    initial begin
        op_in = '0; na_in = '0; ibus_in = '0; din_in = 1'b0;
        sel_in = '0; cin = 1'b0; rst = 1'b1;
        @(negedge clk);
        t_reset();
        t_cont();
        t_jumps();
        t_ir();
        t_save();
        t_loop();
        t_incrpt();
        t_stack();
        t_overflow();
        t_status();
        t_brstat();
        t_unused();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule